// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Port

This block sits between an external debugger's register bus and a processor core. The debugger writes instruction words into an instruction register, hands the core data words through a receive register, and collects words the core returns through a transmit register. A status/control register holds a two-bit transfer mode, full flags for both data registers and a sticky abort flag. Instruction decode and execution are outside the block. The core side is a valid/ready issue handshake, a completion pulse, an abort pulse and simple data handshakes.

In normal mode every instruction write is issued to the core exactly once. In fast mode an instruction write only latches the word. Each later write to the receive register delivers the data word and then reissues the latched instruction to consume it. A block of words therefore costs one bus access per word. Bus accesses stall while the core is still executing or a data register is occupied.

Top module: `dbg_xfer_port`

## Requirements
- R1: After reset the status register (index 34) reads 0, no instruction is offered to the core and accesses are not stalled.
- R2: In normal mode (mode 2'b00) a write to the instruction register (index 33) is offered to the core once and issued exactly once.
- R3: The transfer mode is written to and read back from bits 21:20 of the status register; 2'b10 selects fast mode.
- R4: In fast mode a write to the instruction register latches the word without issuing it.
- R5: In fast mode each accepted write to the receive register (index 35) reissues the latched instruction exactly once.
- R6: In fast mode the data word is already presented to the core (receive valid) when the reissued instruction is offered, and the core receives that word.
- R7: A write to the receive register stalls while an instruction is pending or executing or the receive register is full, and it completes once the core finishes.
- R8: In steady state a block of N words costs exactly N receive-register accesses and produces N issues.
- R9: While the abort flag (status bit 6) is set, no instruction is issued, and fast-mode writes to the receive register are discarded (receive-full, status bit 30, stays 0).
- R10: An abort pulse from the core sets the abort flag, which stays set until a status write with bit 2 equal to 1 clears it; fast-mode reissue then resumes.
- R11: Writing mode 2'b00 discards the latched instruction, so later receive-register writes issue nothing and only set receive-full.
- R12: A word pushed by the core sets transmit-full (status bit 29) and is read at index 32; the read clears transmit-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 6 | Debug register index |
| bus_wdata | input | 32 | Bus write data |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data for the addressed register |
| bus_stall | output | 1 | Access must be held; it is not taken this cycle |
| core_issue_valid | output | 1 | Instruction offered to the core |
| core_issue_insn | output | 32 | Instruction word offered |
| core_issue_ready | input | 1 | Core accepts the offered instruction |
| core_done | input | 1 | Core finished the issued instruction |
| core_abort | input | 1 | Core reports an aborted access |
| core_rx_valid | output | 1 | Receive word available to the core |
| core_rx_data | output | 32 | Receive word |
| core_rx_take | input | 1 | Core consumes the receive word |
| core_tx_push | input | 1 | Core deposits a transmit word |
| core_tx_data | input | 32 | Transmit word from the core |

## Verification
The hardest case to reach is a fast-mode write to the receive register while the aborted flag is set. That needs a latched instruction, a reissue whose completion the core reports as aborted, and then one more data write before the flag is cleared. The bench's core model carries a one-shot abort request that it attaches to the next completion pulse. The bench arms it just before a block word. It then checks that the next word produces no issue and leaves receive-full clear, that the flag survives idle cycles, and that reissue resumes after the clear write.

// File: rtl/dbg_xfer_port.sv
module dbg_xfer_port #(
  parameter int DW      = 32,
  parameter int AW      = 6,
  parameter int TX_IDX  = 32,
  parameter int ITR_IDX = 33,
  parameter int STS_IDX = 34,
  parameter int RX_IDX  = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_stall,
  output logic          core_issue_valid,
  output logic [DW-1:0] core_issue_insn,
  input  logic          core_issue_ready,
  input  logic          core_done,
  input  logic          core_abort,
  output logic          core_rx_valid,
  output logic [DW-1:0] core_rx_data,
  input  logic          core_rx_take,
  input  logic          core_tx_push,
  input  logic [DW-1:0] core_tx_data
);
  localparam logic [AW-1:0] A_TX  = AW'(TX_IDX);
  localparam logic [AW-1:0] A_ITR = AW'(ITR_IDX);
  localparam logic [AW-1:0] A_STS = AW'(STS_IDX);
  localparam logic [AW-1:0] A_RX  = AW'(RX_IDX);
  localparam int MODE_LO = 20;
  localparam int ABT_BIT = 6;
  localparam int CLR_BIT = 2;
  localparam int RXF_BIT = 30;
  localparam int TXF_BIT = 29;
  localparam logic [1:0] MODE_FAST = 2'b10;

  logic [1:0]    mode_q;
  logic [DW-1:0] itr_q, rx_q, tx_q;
  logic          latched_q, pend_q, busy_q, rx_full_q, tx_full_q, abort_q;

  wire fast    = (mode_q == MODE_FAST);
  wire sel_tx  = (bus_addr == A_TX);
  wire sel_itr = (bus_addr == A_ITR);
  wire sel_sts = (bus_addr == A_STS);
  wire sel_rx  = (bus_addr == A_RX);

  wire blk_itr = bus_wr & sel_itr & (busy_q | pend_q);
  wire blk_rx  = bus_wr & sel_rx  & (busy_q | pend_q | rx_full_q);
  wire blk_tx  = bus_rd & sel_tx  & busy_q;
  assign bus_stall = blk_itr | blk_rx | blk_tx;

  wire wr_itr = bus_wr & sel_itr & ~blk_itr;
  wire wr_rx  = bus_wr & sel_rx  & ~blk_rx;
  wire wr_sts = bus_wr & sel_sts;
  wire rd_tx  = bus_rd & sel_tx  & ~blk_tx;
  wire [1:0] new_mode = bus_wdata[MODE_LO+1:MODE_LO];
  wire drop_rx = fast & abort_q;

  assign core_issue_valid = pend_q & ~busy_q & ~abort_q;
  assign core_issue_insn  = itr_q;
  assign core_rx_valid    = rx_full_q;
  assign core_rx_data     = rx_q;
  wire fire = core_issue_valid & core_issue_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; itr_q <= '0; rx_q <= '0; tx_q <= '0;
      latched_q <= 1'b0; pend_q <= 1'b0; busy_q <= 1'b0;
      rx_full_q <= 1'b0; tx_full_q <= 1'b0; abort_q <= 1'b0;
    end else begin
      if (wr_sts) mode_q <= new_mode;
      abort_q <= core_abort | (abort_q & ~(wr_sts & bus_wdata[CLR_BIT]));
      if (wr_itr) itr_q <= bus_wdata;

      if (wr_sts && new_mode != MODE_FAST) latched_q <= 1'b0;
      else if (wr_itr) latched_q <= fast;

      if (fire) pend_q <= 1'b0;
      else if (wr_itr && !fast) pend_q <= 1'b1;
      else if (wr_rx && fast && latched_q && !abort_q) pend_q <= 1'b1;

      if (fire) busy_q <= 1'b1;
      else if (core_done) busy_q <= 1'b0;

      if (wr_rx && !drop_rx) begin
        rx_q <= bus_wdata;
        rx_full_q <= 1'b1;
      end else if (core_rx_take) rx_full_q <= 1'b0;

      if (core_tx_push) begin
        tx_q <= core_tx_data;
        tx_full_q <= 1'b1;
      end else if (rd_tx) tx_full_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_sts) begin
      bus_rdata[MODE_LO+1:MODE_LO] = mode_q;
      bus_rdata[ABT_BIT] = abort_q;
      bus_rdata[RXF_BIT] = rx_full_q;
      bus_rdata[TXF_BIT] = tx_full_q;
    end else if (sel_tx) begin
      bus_rdata = tx_q;
    end
  end
endmodule

// File: rtl/dbg_xfer_port_chk.sv
module dbg_xfer_port_chk #(
  parameter int AW = 6,
  parameter int ITR_IDX = 33,
  parameter int STS_IDX = 34,
  parameter int RX_IDX = 35
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          clr_bit,
  input logic          bus_stall,
  input logic          issue_valid,
  input logic          issue_ready,
  input logic          core_abort,
  input logic          rx_valid,
  input logic [1:0]    mode,
  input logic          latched,
  input logic          abort_flag
);
  localparam logic [AW-1:0] A_ITR = AW'(ITR_IDX);
  localparam logic [AW-1:0] A_STS = AW'(STS_IDX);
  localparam logic [AW-1:0] A_RX  = AW'(RX_IDX);
  wire clr_wr = bus_wr && bus_addr == A_STS && clr_bit;

  a_r2_one_issue_per_accept: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_ready |=> !issue_valid);
  a_r4_fast_itr_latches_only: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 && bus_wr && bus_addr == A_ITR && !bus_stall |=> !issue_valid);
  a_r6_word_ready_at_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && latched |-> rx_valid);
  a_r7_stall_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_valid && issue_ready) && bus_wr && bus_addr == A_RX |-> bus_stall);
  a_r9_no_issue_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_abort) |-> !issue_valid);
  a_r10_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort_flag) && !$past(clr_wr) |-> abort_flag);
endmodule

bind dbg_xfer_port dbg_xfer_port_chk #(.AW(AW), .ITR_IDX(ITR_IDX), .STS_IDX(STS_IDX), .RX_IDX(RX_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .clr_bit(bus_wdata[2]), .bus_stall(bus_stall),
  .issue_valid(core_issue_valid), .issue_ready(core_issue_ready),
  .core_abort(core_abort), .rx_valid(core_rx_valid), .mode(mode_q),
  .latched(latched_q), .abort_flag(abort_q)
);

// File: tb/dbg_xfer_port_bench.sv
module dbg_xfer_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, core_issue_insn, core_rx_data, core_tx_data = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_stall, core_issue_valid, core_rx_valid;
  logic core_issue_ready = 1'b1, core_done = 1'b0, core_abort = 1'b0, core_rx_take = 1'b0;
  logic core_tx_push = 1'b0;

  always #10 clk = ~clk;

  dbg_xfer_port u_dbg_xfer_port (.*);

  int errors = 0, checks = 0;
  int nissue = 0, cnt = 0;
  logic [31:0] last_insn = '0, got = '0;
  logic rx_at_issue = 1'b0, inj = 1'b0;

  localparam logic [31:0] OP_NORM = 32'hA1B2_C3D4;
  localparam logic [31:0] OP_FAST = 32'h5E6F_7081;
  localparam int NW = 4;
  localparam logic [31:0] WORDS [NW] = '{32'h0000_0011, 32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678};

  initial begin
    forever begin
      @(negedge clk);
      core_done = 1'b0; core_rx_take = 1'b0; core_abort = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          core_done = 1'b1;
          if (core_rx_valid) begin core_rx_take = 1'b1; got = core_rx_data; end
          if (inj) begin core_abort = 1'b1; inj = 1'b0; end
        end
      end else if (core_issue_valid && core_issue_ready) begin
        nissue++; last_insn = core_issue_insn; rx_at_issue = core_rx_valid; cnt = 2;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [5:0] a, input logic [31:0] d, output int waits);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1; #1;
    waits = 0;
    while (bus_stall && waits < 50) begin @(negedge clk); #1; waits++; end
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [5:0] a, output logic [31:0] d);
    int w;
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1;
    w = 0;
    while (bus_stall && w < 50) begin @(negedge clk); #1; w++; end
    d = bus_rdata;
    @(posedge clk); #1; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w, base;
    logic [31:0] r;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    bread(6'd34, r);                 chk("R1 status", r, 32'h0);
    chk("R1 issue_valid", {31'b0, core_issue_valid}, 32'h0);
    chk("R1 stall", {31'b0, bus_stall}, 32'h0);

    bwrite(6'd33, OP_NORM, w); repeat (6) @(negedge clk);
    chk("R2 issue count", nissue, 1);  chk("R2 insn", last_insn, OP_NORM);
    repeat (10) @(negedge clk);      chk("R2 no repeat", nissue, 1);

    bwrite(6'd34, 32'h0020_0000, w);
    bread(6'd34, r);                 chk("R3 mode bits", r, 32'h0020_0000);

    bwrite(6'd33, OP_FAST, w); repeat (6) @(negedge clk);
    chk("R4 latched only", nissue, 1);

    base = nissue;
    for (int i = 0; i < NW; i++) begin
      bwrite(6'd35, WORDS[i], w); repeat (6) @(negedge clk);
      chk("R5 reissue", nissue, base + i + 1);
      chk("R5 insn", last_insn, OP_FAST);
      chk("R6 word valid at issue", {31'b0, rx_at_issue}, 32'h1);
      chk("R6 word received", got, WORDS[i]);
    end
    chk("R8 one access per word", nissue - base, NW);

    bwrite(6'd35, 32'hCAFE_0001, w);
    bwrite(6'd35, 32'hCAFE_0002, w);
    chk("R7 second write stalled", {31'b0, w > 0}, 32'h1);
    repeat (8) @(negedge clk);
    chk("R7 both issued", nissue, base + NW + 2);
    chk("R7 last word", got, 32'hCAFE_0002);

    @(negedge clk); core_tx_push = 1'b1; core_tx_data = 32'h0BAD_F00D;
    @(negedge clk); core_tx_push = 1'b0;
    bread(6'd34, r);                 chk("R12 tx full", r, 32'h2020_0000);
    bread(6'd32, r);                 chk("R12 tx data", r, 32'h0BAD_F00D);
    bread(6'd34, r);                 chk("R12 tx cleared", r, 32'h0020_0000);

    inj = 1'b1;
    bwrite(6'd35, 32'h0000_0AAA, w); repeat (8) @(negedge clk);
    base = nissue;
    bread(6'd34, r);                 chk("R10 abort set", r, 32'h0020_0040);
    bwrite(6'd35, 32'h0000_0BBB, w); repeat (6) @(negedge clk);
    chk("R9 no issue while aborted", nissue, base);
    bread(6'd34, r);                 chk("R9 word discarded", r, 32'h0020_0040);
    repeat (20) @(negedge clk);
    bread(6'd34, r);                 chk("R10 sticky", r, 32'h0020_0040);
    bwrite(6'd34, 32'h0020_0004, w);
    bread(6'd34, r);                 chk("R10 cleared", r, 32'h0020_0000);
    bwrite(6'd35, 32'h0000_0CCC, w); repeat (6) @(negedge clk);
    chk("R10 reissue resumes", nissue, base + 1);
    chk("R10 word", got, 32'h0000_0CCC);

    bwrite(6'd34, 32'h0, w);
    base = nissue;
    bwrite(6'd35, 32'h0000_0DDD, w); repeat (8) @(negedge clk);
    chk("R11 no issue after discard", nissue, base);
    bread(6'd34, r);                 chk("R11 rx full", r, 32'h4000_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule